// File: doc/BRIEF.md
# Configurable Output Macrocell Bank

This block is the output stage that sits behind the OR sums of a programmable sum-of-products array. Each cell takes one OR sum and its own output-enable term. It can pass the sum straight to its pad or hold it in a D flip-flop first, and it can invert the result before the pad. It also returns one feedback signal into the array. That feedback comes from the pad input, the flip-flop or the raw OR sum, and the choice does not depend on the output type.

All cells share one synchronous preset term, one clear term and one clock selector. The selector takes either the pin clock or the product-term clock, in true or inverted form. The whole block runs on the system clock `clk`. The selected clock is sampled on each `clk` edge, and a flip-flop update happens on the `clk` edge where the selected clock is seen high after it was low at the previous edge. The clear term acts at once on every register output and also clears the stored state at the next `clk` edge. It does not wait for a selected-clock edge.

Each cell has a 4-bit configuration field:
- bit 0: invert the output
- bit 1: registered output
- bits 3:2: feedback source, where 0 is the pad, 1 is the register, 2 is the OR sum and 3 is reserved and acts as the pad

These give 12 usable configurations.

Top module: `macrocell_bank`

## Requirements
- R1: After synchronous reset, every register holds 0, so a registered, non-inverted cell drives `pad_out` low.
- R2: On a `clk` edge where the selected clock is 1 and was 0 at the previous `clk` edge, each register loads its OR sum. The new value is visible after that edge.
- R3: On a `clk` edge without such a rising edge of the selected clock, and with clear inactive, each register keeps its value, whatever the OR sums do.
- R4: When the preset term is true at a rising selected-clock edge, every register loads 1 instead of its OR sum.
- R5: While the clear term is true, every register output reads 0 at once, with no clock needed. The stored state is also 0 after the next `clk` edge.
- R6: When clear and preset are true together, the registers end up 0.
- R7: `clk_src_sel` = 0 selects `pin_clk` and 1 selects `pt_clk`. `clk_invert` = 1 uses the complement, so a falling edge of the source becomes the capture edge.
- R8: Configuration bit 1 chooses the register output (1) or the OR sum (0) as the value that goes to the pad.
- R9: Configuration bit 0 inverts the value chosen in R8 before it reaches `pad_out`. It does not change the feedback.
- R10: Configuration bits 3:2 choose the feedback. Value 0 gives `pad_in`, 1 gives the true register output, 2 gives the OR sum and 3 gives `pad_in`. The choice does not depend on bits 1:0.
- R11: `pad_oe` of each cell equals that cell's output-enable term.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_cfg | input | 4*N_CELLS | Per-cell configuration, 4 bits per cell |
| clk_src_sel | input | 1 | Clock source: 0 pin, 1 product term |
| clk_invert | input | 1 | Use the complement of the selected clock |
| pin_clk | input | 1 | Clock level from the dedicated pin |
| pt_clk | input | 1 | Clock level from the clock product term |
| or_sum | input | N_CELLS | OR sum per cell |
| oe_term | input | N_CELLS | Output-enable term per cell |
| preset_term | input | 1 | Global synchronous preset |
| clear_term | input | 1 | Global clear |
| pad_in | input | N_CELLS | Input level seen at each pad |
| pad_out | output | N_CELLS | Value driven toward each pad |
| pad_oe | output | N_CELLS | Pad driver enable per cell |
| fb_out | output | N_CELLS | Feedback to the array per cell |

## Verification
The hardest state to reach from the ports is a rising edge of the selected clock that coincides with preset, clear or both, seen through the inverted product-term path. At that point the register's next value depends on all three at once. Directed steps set up these coincidences on purpose: first a low level of the selected clock, then the edge together with the terms. Seeded random stimulus then toggles both clock sources slowly, so that edges through every source and polarity meet random preset and clear pulses under changing cell configurations.

// File: rtl/macrocell_pkg.sv
package macrocell_pkg;

    typedef enum logic [1:0] {
        FB_PAD  = 2'd0,
        FB_REG  = 2'd1,
        FB_SUM  = 2'd2,
        FB_RSVD = 2'd3
    } fb_src_e;

    typedef struct packed {
        fb_src_e fb;
        logic    registered;
        logic    invert;
    } cell_cfg_t;

    localparam int CFG_BITS = $bits(cell_cfg_t);

    function automatic logic apply_polarity(input logic v, input logic inv);
        return v ^ inv;
    endfunction

endpackage

// File: rtl/clk_edge_select.sv
module clk_edge_select (
    input  logic clk,
    input  logic rst,
    input  logic pin_clk,
    input  logic pt_clk,
    input  logic src_sel,
    input  logic invert,
    output logic rise
);
    logic level;
    logic level_q;

    always_comb begin
        level = macrocell_pkg::apply_polarity(src_sel ? pt_clk : pin_clk, invert);
    end

    // Start high after reset so that a level already high is not taken as an edge.
    always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b1;
        else     level_q <= level;
    end

    assign rise = level & ~level_q;
endmodule

// File: rtl/cell_flop.sv
module cell_flop (
    input  logic clk,
    input  logic rst,
    input  logic rise,
    input  logic d,
    input  logic preset,
    input  logic clear,
    output logic q_eff,
    output logic q_state
);
    always_ff @(posedge clk) begin
        if (rst || clear) q_state <= 1'b0;
        else if (rise)    q_state <= preset ? 1'b1 : d;
    end

    // The clear acts on the visible output at once, before any clock.
    assign q_eff = q_state & ~clear;
endmodule

// File: rtl/cell_route.sv
module cell_route
    import macrocell_pkg::*;
(
    input  cell_cfg_t cfg,
    input  logic      sum,
    input  logic      q,
    input  logic      pad_in,
    output logic      pad_out,
    output logic      fb
);
    logic chosen;

    always_comb begin
        chosen  = cfg.registered ? q : sum;
        pad_out = apply_polarity(chosen, cfg.invert);
        unique case (cfg.fb)
            FB_REG:  fb = q;
            FB_SUM:  fb = sum;
            default: fb = pad_in;
        endcase
    end
endmodule

// File: rtl/macrocell_bank.sv
module macrocell_bank
    import macrocell_pkg::*;
#(
    parameter int N_CELLS = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [CFG_BITS*N_CELLS-1:0]   cell_cfg,
    input  logic                          clk_src_sel,
    input  logic                          clk_invert,
    input  logic                          pin_clk,
    input  logic                          pt_clk,
    input  logic [N_CELLS-1:0]            or_sum,
    input  logic [N_CELLS-1:0]            oe_term,
    input  logic                          preset_term,
    input  logic                          clear_term,
    input  logic [N_CELLS-1:0]            pad_in,
    output logic [N_CELLS-1:0]            pad_out,
    output logic [N_CELLS-1:0]            pad_oe,
    output logic [N_CELLS-1:0]            fb_out
);
    logic                 sel_rise;
    logic [N_CELLS-1:0]   q_eff;
    logic [N_CELLS-1:0]   q_state;

    clk_edge_select u_clksel (
        .clk     (clk),
        .rst     (rst),
        .pin_clk (pin_clk),
        .pt_clk  (pt_clk),
        .src_sel (clk_src_sel),
        .invert  (clk_invert),
        .rise    (sel_rise)
    );

    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
        cell_cfg_t cfg_i;
        assign cfg_i = cell_cfg_t'(cell_cfg[CFG_BITS*i +: CFG_BITS]);

        cell_flop u_ff (
            .clk     (clk),
            .rst     (rst),
            .rise    (sel_rise),
            .d       (or_sum[i]),
            .preset  (preset_term),
            .clear   (clear_term),
            .q_eff   (q_eff[i]),
            .q_state (q_state[i])
        );

        cell_route u_route (
            .cfg     (cfg_i),
            .sum     (or_sum[i]),
            .q       (q_eff[i]),
            .pad_in  (pad_in[i]),
            .pad_out (pad_out[i]),
            .fb      (fb_out[i])
        );
    end

    assign pad_oe = oe_term;
endmodule

// File: rtl/macrocell_bank_chk.sv
module macrocell_bank_chk
    import macrocell_pkg::*;
#(
    parameter int N_CELLS = 4
) (
    input logic                        clk,
    input logic                        rst,
    input logic [CFG_BITS*N_CELLS-1:0] cell_cfg,
    input logic                        clk_src_sel,
    input logic                        clk_invert,
    input logic                        pin_clk,
    input logic                        pt_clk,
    input logic [N_CELLS-1:0]          or_sum,
    input logic [N_CELLS-1:0]          oe_term,
    input logic                        preset_term,
    input logic                        clear_term,
    input logic [N_CELLS-1:0]          pad_oe,
    input logic [N_CELLS-1:0]          fb_out,
    input logic [N_CELLS-1:0]          q_state
);
    logic lvl, lvl_q, edge_seen;
    assign lvl       = (clk_src_sel ? pt_clk : pin_clk) ^ clk_invert;
    assign edge_seen = lvl & ~lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b1;
        else     lvl_q <= lvl;
    end

    for (genvar i = 0; i < N_CELLS; i++) begin : g_chk
        // R2
        capture_chk: assert property (@(posedge clk) disable iff (rst)
            (edge_seen && !preset_term && !clear_term) |=> (q_state[i] == $past(or_sum[i])));
        // R3
        hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!edge_seen && !clear_term) |=> $stable(q_state[i]));
        // R4
        preset_chk: assert property (@(posedge clk) disable iff (rst)
            (edge_seen && preset_term && !clear_term) |=> q_state[i]);
        // R5 R6
        clear_chk: assert property (@(posedge clk) disable iff (rst)
            clear_term |=> !q_state[i]);
        // R5
        clear_now_chk: assert property (@(posedge clk) disable iff (rst)
            (clear_term && cell_cfg[CFG_BITS*i+2 +: 2] == 2'd1) |-> !fb_out[i]);
        // R11
        oe_chk: assert property (@(posedge clk) disable iff (rst)
            pad_oe[i] == oe_term[i]);
    end
endmodule

bind macrocell_bank macrocell_bank_chk #(.N_CELLS(N_CELLS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cell_cfg    (cell_cfg),
    .clk_src_sel (clk_src_sel),
    .clk_invert  (clk_invert),
    .pin_clk     (pin_clk),
    .pt_clk      (pt_clk),
    .or_sum      (or_sum),
    .oe_term     (oe_term),
    .preset_term (preset_term),
    .clear_term  (clear_term),
    .pad_oe      (pad_oe),
    .fb_out      (fb_out),
    .q_state     (q_state)
);

// File: tb/sim_macrocell_bank.sv
module sim_macrocell_bank;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst;
    logic [4*N-1:0] cell_cfg;
    logic clk_src_sel, clk_invert, pin_clk, pt_clk, preset_term, clear_term;
    logic [N-1:0] or_sum, oe_term, pad_in, pad_out, pad_oe, fb_out;

    int n_checks = 0;
    int n_fail   = 0;
    logic [N-1:0] mq;
    logic         mprev;

    always #2 clk = ~clk;

    macrocell_bank #(.N_CELLS(N)) u0 (
        .clk(clk), .rst(rst), .cell_cfg(cell_cfg), .clk_src_sel(clk_src_sel),
        .clk_invert(clk_invert), .pin_clk(pin_clk), .pt_clk(pt_clk),
        .or_sum(or_sum), .oe_term(oe_term), .preset_term(preset_term),
        .clear_term(clear_term), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .fb_out(fb_out)
    );

    function automatic logic sel_level();
        return (clk_src_sel ? pt_clk : pin_clk) ^ clk_invert;
    endfunction

    function automatic logic q_vis(int i);
        return clear_term ? 1'b0 : mq[i];
    endfunction

    function automatic logic exp_pad(int i);
        logic v;
        v = cell_cfg[4*i+1] ? q_vis(i) : or_sum[i];
        return v ^ cell_cfg[4*i];
    endfunction

    function automatic logic exp_fb(int i);
        case (cell_cfg[4*i+2 +: 2])
            2'd1:    return q_vis(i);
            2'd2:    return or_sum[i];
            default: return pad_in[i];
        endcase
    endfunction

    task automatic check(input logic got, input logic exp, input string tag, input int i);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s cell %0d: got %b expected %b", tag, i, got, exp);
        end
    endtask

    // Inputs must already be applied after a negedge; checks, then advances over one posedge.
    task automatic step(input string tag);
        logic [N-1:0] nq;
        logic         rise;
        #1;
        for (int i = 0; i < N; i++) begin
            check(pad_out[i], exp_pad(i), {tag, " pad_out R8 R9"}, i);
            check(fb_out[i],  exp_fb(i),  {tag, " fb_out R10"}, i);
            check(pad_oe[i],  oe_term[i], {tag, " pad_oe R11"}, i);
        end
        rise = sel_level() & ~mprev;
        nq = mq;
        if (clear_term)  nq = '0;
        else if (rise)   nq = preset_term ? '1 : or_sum;
        @(posedge clk);
        mq = nq;
        mprev = sel_level();
        @(negedge clk);
    endtask

    initial begin : watchdog
        #400000;
        n_fail++;
        $display("FAIL watchdog: got hang expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; cell_cfg = {N{4'b0110}}; // registered, true polarity, register feedback
        clk_src_sel = 0; clk_invert = 0; pin_clk = 0; pt_clk = 0;
        preset_term = 0; clear_term = 0; or_sum = '0; oe_term = 4'b1010; pad_in = 4'b0110;
        repeat (3) @(negedge clk);
        rst = 1'b0; mq = '0; mprev = 1'b1;
        // R1 reset state
        or_sum = 4'b1111; step("R1");

        // R2 capture on rising selected clock
        pin_clk = 0; or_sum = 4'b1010; step("R2 low");
        pin_clk = 1; step("R2 edge");
        // R3 no new edge: value held
        or_sum = 4'b0101; step("R3 hold");
        step("R3 hold2");

        // R4 preset on edge
        pin_clk = 0; step("R4 low");
        pin_clk = 1; preset_term = 1; or_sum = '0; step("R4 edge");
        preset_term = 0; step("R4 after");

        // R5 clear acts at once
        clear_term = 1; step("R5 clear");
        clear_term = 0; step("R5 after");

        // R4 R6 preset and clear together
        pin_clk = 0; step("R6 low");
        pin_clk = 1; preset_term = 1; clear_term = 1; step("R6 edge");
        preset_term = 0; clear_term = 0; step("R6 after");

        // R7 inverted product-term clock: falling pt_clk captures
        clk_src_sel = 1; clk_invert = 1; pt_clk = 1; step("R7 setup");
        pt_clk = 0; or_sum = 4'b0011; pin_clk = 0; step("R7 edge");
        pin_clk = 1; or_sum = 4'b1100; step("R7 pin ignored");
        step("R7 after");

        // R9 R10 all feedback and polarity codes
        cell_cfg = {4'b1111, 4'b1001, 4'b0100, 4'b0011};
        pad_in = 4'b1001; step("R10 codes");

        // Seeded random
        for (int c = 0; c < 600; c++) begin
            if (c % 20 == 0) begin
                cell_cfg    = 16'($urandom);
                clk_src_sel = 1'($urandom);
                clk_invert  = 1'($urandom);
            end
            if ($urandom % 3 == 0) pin_clk = ~pin_clk;
            if ($urandom % 3 == 0) pt_clk  = ~pt_clk;
            preset_term = ($urandom % 5 == 0);
            clear_term  = ($urandom % 9 == 0);
            or_sum  = 4'($urandom);
            oe_term = 4'($urandom);
            pad_in  = 4'($urandom);
            step("rand R2 R3 R4 R5 R6 R7");
        end

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule